// File: doc/BRIEF.md
# Bridge Read Termination Handler

This block controls the read path of a bridge. On one side a local-bus slave presents fixed-length read requests. On the other side a PCI-style initiator issues read transactions. The handler accepts a request and checks that the whole burst fits inside the bridge window. It then starts one or more initiator transactions until every requested word has been prefetched. Each accepted data phase is written into a prefetch buffer, which lies outside this block.

Every PCI transaction ends with an abstract termination code. The handler classifies that code and takes one of three actions:

- issue the read again for the words still missing;
- complete the request normally;
- abandon the request, flush the buffered words and return a read error.

A request is treated as a burst when its length is more than one word, or when it is flagged as a cacheline read. The handler raises single-cycle interrupt pulses for these causes: window overrun, system error, data parity error and target abort.

Top module: `rd_term_handler`

## Requirements
- R1: A request is an overrun when its last byte (address + 4*length - 1) lies above parameter WIN_HI. An overrun request never asserts pci_start. In the cycle after the request is accepted, irq_ovr, lb_done and lb_err are all high.
- R2: Two termination codes cause a reissue while words remain outstanding: code 1 (retry) and code 3 (disconnect without data). The reissue is the next pci_start. Its pci_addr is the request address plus 4 times the number of words accepted so far, and its pci_cnt is the number of words still outstanding.
- R3: On a burst, three more codes end the current transaction: code 0 (normal end), code 2 (disconnect with data) and code 4 (latency-timer expiry). The handler starts a new transaction, addressed as in R2, while words remain. It completes without error once all words have been accepted.
- R4: On a single transfer, code 2 with a data phase in the same cycle delivers the word and completes without error after exactly one transaction.
- R5: On a single transfer, code 5 (data parity error) still delivers the word. It pulses irq_perr and completes with lb_err low.
- R6: On a burst, code 5 drops the data phase in the same cycle, pulses irq_perr and completes with lb_err high. A one-word read flagged with req_line counts as a burst.
- R7: Code 6 (system error during data) drops the data phase in the same cycle, pulses irq_serr and completes with lb_err high. This holds for single and burst reads.
- R8: Code 9 (address parity error, target did not claim) and code 10 (address parity error, target transferred data) both pulse irq_serr. Neither delivers a word, and both complete with lb_err high.
- R9: Code 7 (master abort) completes with lb_err high and raises no interrupt. Code 8 (target abort) drops the data phase in the same cycle, pulses irq_tabort and completes with lb_err high.
- R10: Each request produces exactly one lb_done pulse, and req_ready is high again in the following cycle. Every error completion also pulses pf_flush. No pf_wr occurs once the error decision has been made.
- R11: Every interrupt output is high for one cycle per event. Data phases beyond the remaining word count are ignored and produce no pf_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local read request present |
| req_ready | output | 1 | Handler idle, request accepted when valid |
| req_addr | input | ADDR_W | Byte address of first word |
| req_len | input | LEN_W | Number of 32-bit words, 1 or more |
| req_line | input | 1 | Cacheline read flag |
| pci_start | output | 1 | Start an initiator read transaction |
| pci_addr | output | ADDR_W | Start address of the transaction |
| pci_cnt | output | LEN_W | Words still to prefetch |
| pci_dvalid | input | 1 | Data phase completed on the bus |
| pci_data | input | DATA_W | Data of the data phase |
| pci_term | input | 1 | Transaction termination strobe |
| pci_code | input | 4 | Termination cause code |
| pf_wr | output | 1 | Write accepted word into prefetch buffer |
| pf_data | output | DATA_W | Word to write |
| pf_flush | output | 1 | Discard buffered words |
| lb_done | output | 1 | Request completion to local master (data acknowledge) |
| lb_err | output | 1 | Completion carries a read error |
| irq_ovr | output | 1 | Window overrun interrupt pulse |
| irq_serr | output | 1 | System error interrupt pulse |
| irq_perr | output | 1 | Data parity interrupt pulse |
| irq_tabort | output | 1 | Target abort interrupt pulse |

## Verification
On every cycle the assertions check the following:

- An overrun, system error or target abort interrupt coincides with an error completion.
- Completions and interrupts are single pulses.
- No buffer write happens on a completion cycle or with zero words remaining.
- A transaction start is never followed directly by a completion.

Only the bench's scenarios can show the rest. That includes the choice between reissue, normal completion and abandon for each termination code, under single, burst and cacheline requests. It also includes the resume address and count of each reissued transaction, the exact number of words delivered, and the exact-fit window boundary.

// File: rtl/rd_term_handler.sv
module rd_term_handler #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 5,
  parameter logic [ADDR_W-1:0] WIN_HI = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_line,
  output logic              pci_start,
  output logic [ADDR_W-1:0] pci_addr,
  output logic [LEN_W-1:0]  pci_cnt,
  input  logic              pci_dvalid,
  input  logic [DATA_W-1:0] pci_data,
  input  logic              pci_term,
  input  logic [3:0]        pci_code,
  output logic              pf_wr,
  output logic [DATA_W-1:0] pf_data,
  output logic              pf_flush,
  output logic              lb_done,
  output logic              lb_err,
  output logic              irq_ovr,
  output logic              irq_serr,
  output logic              irq_perr,
  output logic              irq_tabort
);
  localparam int EW = ADDR_W + 2;
  localparam logic [3:0] C_NORM = 4'd0, C_RETRY = 4'd1, C_DISC_D = 4'd2,
                         C_DISC_N = 4'd3, C_LTIM = 4'd4, C_PERR = 4'd5,
                         C_SERR = 4'd6, C_MABT = 4'd7, C_TABT = 4'd8,
                         C_APE_N = 4'd9, C_APE_X = 4'd10;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_XFER, S_FIN} st_t;
  st_t st;

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q, rem_nx;
  logic              burst_q, err_q;
  logic              ovr, benign, drop, acc;
  logic [EW-1:0]     last_b;

  assign last_b = EW'(req_addr) + (EW'(req_len) << 2) - EW'(1);
  assign ovr    = last_b > EW'(WIN_HI);

  assign benign = (pci_code <= C_LTIM) || (pci_code == C_PERR && !burst_q);
  assign drop   = pci_term && !benign && pci_code != C_MABT;
  assign acc    = (st == S_XFER) && pci_dvalid && (rem_q != '0) && !drop &&
                  !(pci_term && !benign);
  assign rem_nx = rem_q - LEN_W'(acc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      addr_q     <= '0;
      rem_q      <= '0;
      burst_q    <= 1'b0;
      err_q      <= 1'b0;
      irq_ovr    <= 1'b0;
      irq_serr   <= 1'b0;
      irq_perr   <= 1'b0;
      irq_tabort <= 1'b0;
    end else begin
      irq_ovr    <= 1'b0;
      irq_serr   <= 1'b0;
      irq_perr   <= 1'b0;
      irq_tabort <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          rem_q   <= req_len;
          burst_q <= req_line || (req_len > LEN_W'(1));
          err_q   <= ovr;
          irq_ovr <= ovr;
          st      <= ovr ? S_FIN : S_ISSUE;
        end
        S_ISSUE: st <= S_XFER;
        S_XFER: begin
          if (acc) begin
            addr_q <= addr_q + ADDR_W'(4);
            rem_q  <= rem_nx;
          end
          if (pci_term) begin
            irq_serr   <= pci_code == C_SERR || pci_code == C_APE_N ||
                          pci_code == C_APE_X;
            irq_perr   <= pci_code == C_PERR;
            irq_tabort <= pci_code == C_TABT;
            if (!benign) begin
              err_q <= 1'b1;
              st    <= S_FIN;
            end else if (rem_nx == '0) begin
              st <= S_FIN;
            end else begin
              st <= S_ISSUE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = st == S_IDLE;
  assign pci_start = st == S_ISSUE;
  assign pci_addr  = addr_q;
  assign pci_cnt   = rem_q;
  assign pf_wr     = acc;
  assign pf_data   = pci_data;
  assign lb_done   = st == S_FIN;
  assign lb_err    = lb_done && err_q;
  assign pf_flush  = lb_err;
endmodule

// File: rtl/rd_term_handler_chk.sv
module rd_term_handler_chk #(
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             pci_start,
  input logic [LEN_W-1:0] pci_cnt,
  input logic             pf_wr,
  input logic             lb_done,
  input logic             lb_err,
  input logic             irq_ovr,
  input logic             irq_serr,
  input logic             irq_perr,
  input logic             irq_tabort
);
  p_ovr_no_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovr |-> lb_done && lb_err && !pci_start);
  p_serr_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_serr |-> lb_done && lb_err);
  p_tabort_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tabort |-> lb_done && lb_err);
  p_start_then_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pci_start |=> !pci_start && !lb_done);
  p_one_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lb_done |=> !lb_done && req_ready);
  p_no_push_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lb_done |-> !pf_wr);
  p_push_in_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pf_wr |-> pci_cnt != '0);
  p_perr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_perr |=> !irq_perr);
  p_serr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_serr |=> !irq_serr);
endmodule

bind rd_term_handler rd_term_handler_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .pci_start(pci_start),
  .pci_cnt(pci_cnt), .pf_wr(pf_wr), .lb_done(lb_done), .lb_err(lb_err),
  .irq_ovr(irq_ovr), .irq_serr(irq_serr), .irq_perr(irq_perr),
  .irq_tabort(irq_tabort)
);

// File: tb/rd_term_handler_test.sv
`timescale 1ns/1ps
module rd_term_handler_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_line = 1'b0;
  logic [31:0] req_addr = '0;
  logic [4:0]  req_len = '0;
  logic        pci_dvalid = 1'b0, pci_term = 1'b0;
  logic [31:0] pci_data = '0;
  logic [3:0]  pci_code = '0;
  logic        req_ready, pci_start, pf_wr, pf_flush, lb_done, lb_err;
  logic        irq_ovr, irq_serr, irq_perr, irq_tabort;
  logic [31:0] pci_addr, pf_data;
  logic [4:0]  pci_cnt;

  always #2.5 clk = ~clk;

  rd_term_handler uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_line(req_line),
    .pci_start(pci_start), .pci_addr(pci_addr), .pci_cnt(pci_cnt),
    .pci_dvalid(pci_dvalid), .pci_data(pci_data), .pci_term(pci_term),
    .pci_code(pci_code), .pf_wr(pf_wr), .pf_data(pf_data), .pf_flush(pf_flush),
    .lb_done(lb_done), .lb_err(lb_err), .irq_ovr(irq_ovr), .irq_serr(irq_serr),
    .irq_perr(irq_perr), .irq_tabort(irq_tabort)
  );

  typedef struct packed {
    logic [4:0] len; logic line; logic [3:0] code; logic [2:0] nd; logic dt;
    logic e_err; logic [2:0] e_irq; logic [4:0] e_push; logic [1:0] e_starts;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{5'd1, 1'b0, 4'd0,  3'd0, 1'b1, 1'b0, 3'b000, 5'd1, 2'd1},
    '{5'd4, 1'b0, 4'd0,  3'd3, 1'b1, 1'b0, 3'b000, 5'd4, 2'd1},
    '{5'd1, 1'b0, 4'd1,  3'd0, 1'b0, 1'b0, 3'b000, 5'd1, 2'd2},
    '{5'd4, 1'b0, 4'd1,  3'd0, 1'b0, 1'b0, 3'b000, 5'd4, 2'd2},
    '{5'd4, 1'b0, 4'd2,  3'd1, 1'b1, 1'b0, 3'b000, 5'd4, 2'd2},
    '{5'd4, 1'b0, 4'd3,  3'd2, 1'b0, 1'b0, 3'b000, 5'd4, 2'd2},
    '{5'd4, 1'b0, 4'd4,  3'd1, 1'b1, 1'b0, 3'b000, 5'd4, 2'd2},
    '{5'd1, 1'b0, 4'd2,  3'd0, 1'b1, 1'b0, 3'b000, 5'd1, 2'd1},
    '{5'd1, 1'b0, 4'd5,  3'd0, 1'b1, 1'b0, 3'b010, 5'd1, 2'd1},
    '{5'd4, 1'b0, 4'd5,  3'd2, 1'b1, 1'b1, 3'b010, 5'd2, 2'd1},
    '{5'd1, 1'b1, 4'd5,  3'd0, 1'b1, 1'b1, 3'b010, 5'd0, 2'd1},
    '{5'd1, 1'b0, 4'd6,  3'd0, 1'b1, 1'b1, 3'b100, 5'd0, 2'd1},
    '{5'd4, 1'b0, 4'd6,  3'd1, 1'b1, 1'b1, 3'b100, 5'd1, 2'd1},
    '{5'd4, 1'b0, 4'd7,  3'd0, 1'b0, 1'b1, 3'b000, 5'd0, 2'd1},
    '{5'd4, 1'b0, 4'd8,  3'd2, 1'b1, 1'b1, 3'b001, 5'd2, 2'd1},
    '{5'd4, 1'b0, 4'd9,  3'd0, 1'b0, 1'b1, 3'b100, 5'd0, 2'd1},
    '{5'd4, 1'b0, 4'd10, 3'd0, 1'b1, 1'b1, 3'b100, 5'd0, 2'd1},
    '{5'd2, 1'b0, 4'd0,  3'd2, 1'b1, 1'b0, 3'b000, 5'd2, 2'd1},
    '{5'd4, 1'b1, 4'd3,  3'd1, 1'b0, 1'b0, 3'b000, 5'd4, 2'd2}
  };

  function automatic string tag(int i);
    case (i)
      0, 1: return "R3";
      2, 3: return "R2";
      4, 5, 6, 18: return "R3";
      7: return "R4";
      8: return "R5";
      9, 10: return "R6";
      11, 12: return "R7";
      13, 14: return "R9";
      15, 16: return "R8";
      default: return "R11";
    endcase
  endfunction

  int n_chk = 0, n_fail = 0;
  int push_cnt, start_cnt, done_cnt, flush_cnt, err_seen;
  logic [2:0] irq_seen;
  logic ovr_seen, p_serr, p_perr, p_tab, p_ovr;
  logic [31:0] cur_base;
  int cur_len;
  bit wd = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (pf_wr) push_cnt++;
      if (pf_flush) flush_cnt++;
      if (lb_done) begin done_cnt++; if (lb_err) err_seen++; end
      if (irq_serr) irq_seen[2] = 1'b1;
      if (irq_perr) irq_seen[1] = 1'b1;
      if (irq_tabort) irq_seen[0] = 1'b1;
      if (irq_ovr) ovr_seen = 1'b1;
      if ((irq_serr && p_serr) || (irq_perr && p_perr) || (irq_tabort && p_tab) || (irq_ovr && p_ovr))
        chk(1'b0, "R11 irq width", 2, 1);
      if (pci_start) begin
        start_cnt++;
        chk(pci_addr == cur_base + 32'(4 * push_cnt), "R2 resume addr", int'(pci_addr), int'(cur_base) + 4 * push_cnt);
        chk(int'(pci_cnt) == cur_len - push_cnt, "R3 resume count", int'(pci_cnt), cur_len - push_cnt);
      end
    end
    p_serr = irq_serr; p_perr = irq_perr; p_tab = irq_tabort; p_ovr = irq_ovr;
  end

  task automatic serve(logic [3:0] c, int n, bit d);
    @(posedge clk); #1;
    for (int k = 0; k < n; k++) begin
      pci_dvalid = 1'b1; pci_data = $urandom;
      @(posedge clk); #1;
    end
    pci_dvalid = d; pci_data = $urandom; pci_term = 1'b1; pci_code = c;
    @(posedge clk); #1;
    pci_dvalid = 1'b0; pci_term = 1'b0; pci_code = '0;
  endtask

  task automatic run_req(logic [31:0] a, int len, bit line, logic [3:0] c, int nd, bit dt);
    bit first = 1;
    push_cnt = 0; start_cnt = 0; done_cnt = 0; flush_cnt = 0; err_seen = 0;
    irq_seen = '0; ovr_seen = 1'b0; cur_base = a; cur_len = len;
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_len = 5'(len); req_line = line;
    @(posedge clk); #1;
    req_valid = 1'b0; req_line = 1'b0;
    for (int g = 0; g < 60; g++) begin
      if (pci_start) begin
        if (first) serve(c, nd, dt);
        else serve(4'd0, int'(pci_cnt) - 1, 1'b1);
        first = 0;
      end else if (lb_done) begin
        break;
      end else begin
        @(posedge clk); #1;
      end
    end
    @(posedge clk); #1;
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !pci_start && !lb_done && !pf_wr, "R10 reset ready", int'(req_ready), 1);
        chk({irq_ovr, irq_serr, irq_perr, irq_tabort} == 4'b0, "R11 reset irqs", int'({irq_ovr, irq_serr, irq_perr, irq_tabort}), 0);

        for (int i = 0; i < NV; i++) begin
          run_req(32'h100, int'(TBL[i].len), TBL[i].line, TBL[i].code, int'(TBL[i].nd), TBL[i].dt);
          chk(err_seen == int'(TBL[i].e_err), tag(i), err_seen, int'(TBL[i].e_err));
          chk(irq_seen == TBL[i].e_irq, tag(i), int'(irq_seen), int'(TBL[i].e_irq));
          chk(push_cnt == int'(TBL[i].e_push), tag(i), push_cnt, int'(TBL[i].e_push));
          chk(start_cnt == int'(TBL[i].e_starts), tag(i), start_cnt, int'(TBL[i].e_starts));
          chk(flush_cnt == int'(TBL[i].e_err), "R10 flush", flush_cnt, int'(TBL[i].e_err));
          chk(done_cnt == 1 && req_ready, "R10 one completion", done_cnt, 1);
        end

        // R1 burst crossing window top
        run_req(32'h0000_FFF8, 4, 1'b0, 4'd0, 3, 1'b1);
        chk(start_cnt == 0, "R1 no start", start_cnt, 0);
        chk(ovr_seen && err_seen == 1, "R1 overrun error", err_seen, 1);
        chk(done_cnt == 1, "R1 one completion", done_cnt, 1);
        // R1 single word beyond window
        run_req(32'h0001_0000, 1, 1'b0, 4'd0, 0, 1'b1);
        chk(start_cnt == 0 && ovr_seen, "R1 single overrun", start_cnt, 0);
        // R1 exact fit is not an overrun
        run_req(32'h0000_FFF0, 4, 1'b0, 4'd0, 3, 1'b1);
        chk(!ovr_seen && err_seen == 0, "R1 exact fit", err_seen, 0);
        chk(push_cnt == 4 && start_cnt == 1, "R1 exact fit words", push_cnt, 4);
      end
      begin
        repeat (100000) @(posedge clk);
        wd = 1;
      end
    join_any
    disable fork;
    if (wd) chk(1'b0, "R10 watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule